// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block drives the gate-open vector of one egress port that serves eight traffic-class queues. Software loads a short table of schedule entries. Each entry pairs a gate mask with a hold time in nanoseconds. The block then steps through the entries one after another and returns to entry 0 after the last one. Time is measured with a free-running local tick strobe, and each tick is worth a fixed number of nanoseconds set by a parameter. No network time reference is used.

Raising the enable input starts the schedule on the next clock. No base time is involved: the schedule always begins at entry 0 with its full hold time. When the schedule is stopped or has been rejected, every gate stays open.

Each time the gate vector takes on a new entry, the block emits a one-cycle change pulse. A neighbouring port can report, through an input, that its own gate event falls in the same cycle. If that report arrives together with a local change pulse, the block raises a sticky conflict flag. A table that is unusable at start is rejected and flagged.

Top module: `gate_sched`

## Requirements
- R1: While the enable input is low, the gate output is all ones (every class open) and no change pulse is produced. The output reaches this state from the first clock after enable is sampled low.
- R2: While the schedule runs, bit n of the gate output equals bit n of the current entry's mask, so a 1 in bit n opens the gate of class n.
- R3: On the clock that samples enable going from 0 to 1 with a valid table, the schedule restarts at entry 0 with its elapsed time cleared. Any earlier position and elapsed time are discarded.
- R4: An entry of interval I stays in force for exactly ceil(I / TICK_NS) tick strobes. A clock with the tick input low does not advance time.
- R5: After entry num_entries-1 expires, the schedule moves to entry 0. With one entry, that entry repeats and the change pulse fires again at each expiry.
- R6: entry_chg_o is high for exactly the one clock in which the gate output first shows a newly loaded entry, both at start and on every advance. At no other time does the gate output change while enable stays high and no table write occurs.
- R7: If peer_event_i is high in a cycle where entry_chg_o is high, conflict_err_o goes high on the next clock. It stays high until the next rising edge of enable clears it. peer_event_i has no effect in cycles without a change pulse.
- R8: On an enable rising edge, cfg_err_o is set and the schedule is not started (gates stay all open, no pulse) if num_entries_i is outside 1..16 or any of entries 0..num_entries_i-1 has a zero interval. Entries at or above num_entries_i are not checked. The flag holds until the next enable rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 4 | Entry index written |
| wr_mask_i | input | 8 | Gate mask written |
| wr_ivl_i | input | 24 | Interval written, in ns |
| num_entries_i | input | 5 | Number of active entries, sampled at start |
| enable_i | input | 1 | Run the schedule (level) |
| tick_i | input | 1 | Local time strobe, worth TICK_NS ns |
| peer_event_i | input | 1 | Another port has a gate event this cycle |
| gate_o | output | 8 | Gate-open vector, bit n for class n |
| entry_chg_o | output | 1 | Pulse when a new entry takes effect |
| conflict_err_o | output | 1 | Sticky coincident-event error |
| cfg_err_o | output | 1 | Sticky rejected-table error |

## Verification
If the entry index is wrong, the gate output shows a mask from the wrong entry on the very clock the change pulse fires. The directed schedules use a distinct mask for every entry, so a wrong index cannot go unseen. If the elapsed-time counter is wrong, the change appears one or more ticks early or late. The tests therefore probe the gate on the tick just before each expected change and on the tick of the change itself, including after a restart in mid-entry. Faults in the error flags are found within one clock of the triggering event, and the tests also check that these flags stay set afterwards.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
   typedef enum logic [0:0] {
      SCH_OFF = 1'b0,
      SCH_RUN = 1'b1
   } sch_state_e;
endpackage

// File: rtl/gsched_table.sv
module gsched_table #(
   parameter int NUM_TC      = 8,
   parameter int MAX_ENTRIES = 16,
   parameter int IVL_W       = 24,
   localparam int IDX_W      = $clog2(MAX_ENTRIES),
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [NUM_TC-1:0] wr_mask_i,
   input  logic [IVL_W-1:0]  wr_ivl_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  logic [CNT_W-1:0]  chk_count_i,
   output logic [NUM_TC-1:0] rd_mask_o,
   output logic [IVL_W-1:0]  rd_ivl_o,
   output logic              zero_hit_o
);
   logic [NUM_TC-1:0] mask_q [MAX_ENTRIES];
   logic [IVL_W-1:0]  ivl_q  [MAX_ENTRIES];
   logic              idx_ok;

   assign idx_ok = {1'b0, wr_idx_i} < (IDX_W+1)'(MAX_ENTRIES);

   for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_q[e] <= '0;
            ivl_q[e]  <= '0;
         end else if (wr_en_i && idx_ok && (wr_idx_i == IDX_W'(e))) begin
            mask_q[e] <= wr_mask_i;
            ivl_q[e]  <= wr_ivl_i;
         end
      end
   end

   assign rd_mask_o = mask_q[rd_idx_i];
   assign rd_ivl_o  = ivl_q[rd_idx_i];

   always_comb begin
      zero_hit_o = 1'b0;
      for (int e = 0; e < MAX_ENTRIES; e++) begin
         if ((CNT_W'(e) < chk_count_i) && (ivl_q[e] == '0)) zero_hit_o = 1'b1;
      end
   end
endmodule

// File: rtl/gsched_timer.sv
module gsched_timer #(
   parameter int IVL_W   = 24,
   parameter int TICK_NS = 10,
   localparam int SUM_W  = IVL_W + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             tick_en_i,
   input  logic [IVL_W-1:0] ivl_i,
   output logic             expire_o
);
   logic [IVL_W-1:0] elapsed_q;
   logic [SUM_W-1:0] next_sum;

   assign next_sum = {1'b0, elapsed_q} + SUM_W'(TICK_NS);
   assign expire_o = tick_en_i && !restart_i && (next_sum >= {1'b0, ivl_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          elapsed_q <= '0;
      else if (restart_i)   elapsed_q <= '0;
      else if (expire_o)    elapsed_q <= '0;
      else if (tick_en_i)   elapsed_q <= next_sum[IVL_W-1:0];
   end
endmodule

// File: rtl/gsched_seq.sv
module gsched_seq
   import gsched_pkg::*;
#(
   parameter int MAX_ENTRIES = 16,
   localparam int IDX_W      = $clog2(MAX_ENTRIES),
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] num_entries_i,
   input  logic             zero_hit_i,
   input  logic             expire_i,
   input  logic             peer_event_i,
   output logic             run_o,
   output logic             restart_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             chg_o,
   output logic             conflict_o,
   output logic             cfg_err_o
);
   sch_state_e       state_q;
   logic             en_q;
   logic [CNT_W-1:0] num_q;
   logic [IDX_W-1:0] idx_q;
   logic             chg_q, conflict_q, cfg_q;
   logic             num_bad, start_bad, at_last;

   assign restart_o = enable_i && !en_q;
   assign num_bad   = (num_entries_i == '0) ||
                      (num_entries_i > CNT_W'(MAX_ENTRIES));
   assign start_bad = num_bad || zero_hit_i;
   assign at_last   = (CNT_W'(idx_q) == (num_q - CNT_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q       <= 1'b0;
         state_q    <= SCH_OFF;
         num_q      <= '0;
         idx_q      <= '0;
         chg_q      <= 1'b0;
         conflict_q <= 1'b0;
         cfg_q      <= 1'b0;
      end else begin
         en_q <= enable_i;
         if (chg_q && peer_event_i) conflict_q <= 1'b1;
         if (restart_o) begin
            state_q    <= start_bad ? SCH_OFF : SCH_RUN;
            num_q      <= num_entries_i;
            idx_q      <= '0;
            chg_q      <= !start_bad;
            cfg_q      <= start_bad;
            conflict_q <= 1'b0;
         end else if (!enable_i) begin
            state_q <= SCH_OFF;
            chg_q   <= 1'b0;
         end else if ((state_q == SCH_RUN) && expire_i) begin
            idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
            chg_q <= 1'b1;
         end else begin
            chg_q <= 1'b0;
         end
      end
   end

   assign run_o      = (state_q == SCH_RUN);
   assign idx_o      = idx_q;
   assign chg_o      = chg_q;
   assign conflict_o = conflict_q;
   assign cfg_err_o  = cfg_q;
endmodule

// File: rtl/gate_sched.sv
module gate_sched #(
   parameter int NUM_TC      = 8,
   parameter int MAX_ENTRIES = 16,
   parameter int IVL_W       = 24,
   parameter int TICK_NS     = 10,
   parameter bit REG_GATE    = 1'b0,
   localparam int IDX_W      = $clog2(MAX_ENTRIES),
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [NUM_TC-1:0] wr_mask_i,
   input  logic [IVL_W-1:0]  wr_ivl_i,
   input  logic [CNT_W-1:0]  num_entries_i,
   input  logic              enable_i,
   input  logic              tick_i,
   input  logic              peer_event_i,
   output logic [NUM_TC-1:0] gate_o,
   output logic              entry_chg_o,
   output logic              conflict_err_o,
   output logic              cfg_err_o
);
   if (NUM_TC < 1 || MAX_ENTRIES < 2 || IVL_W < 2 || TICK_NS < 1 ||
       TICK_NS >= (2 ** IVL_W)) begin : g_param_bad
      $error("gate_sched: illegal parameter set");
   end

   logic              run, restart, expire, zero_hit, chg;
   logic [IDX_W-1:0]  idx;
   logic [NUM_TC-1:0] cur_mask, gate_d;
   logic [IVL_W-1:0]  cur_ivl;

   gsched_table #(
      .NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES), .IVL_W(IVL_W)
   ) u_table (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
      .wr_mask_i(wr_mask_i), .wr_ivl_i(wr_ivl_i),
      .rd_idx_i(idx), .chk_count_i(num_entries_i),
      .rd_mask_o(cur_mask), .rd_ivl_o(cur_ivl), .zero_hit_o(zero_hit)
   );

   gsched_timer #(.IVL_W(IVL_W), .TICK_NS(TICK_NS)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .restart_i(restart), .tick_en_i(tick_i && run),
      .ivl_i(cur_ivl), .expire_o(expire)
   );

   gsched_seq #(.MAX_ENTRIES(MAX_ENTRIES)) u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .enable_i(enable_i), .num_entries_i(num_entries_i),
      .zero_hit_i(zero_hit), .expire_i(expire), .peer_event_i(peer_event_i),
      .run_o(run), .restart_o(restart), .idx_o(idx), .chg_o(chg),
      .conflict_o(conflict_err_o), .cfg_err_o(cfg_err_o)
   );

   assign gate_d = run ? cur_mask : '1;

   if (REG_GATE) begin : g_reg_out
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            gate_o      <= '1;
            entry_chg_o <= 1'b0;
         end else begin
            gate_o      <= gate_d;
            entry_chg_o <= chg;
         end
      end
   end else begin : g_comb_out
      assign gate_o      = gate_d;
      assign entry_chg_o = chg;
   end
endmodule

// File: rtl/gate_sched_chk.sv
module gate_sched_chk #(
   parameter int NUM_TC   = 8,
   parameter bit REG_GATE = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic              enable_i,
   input logic              peer_event_i,
   input logic [NUM_TC-1:0] gate_o,
   input logic              entry_chg_o,
   input logic              conflict_err_o,
   input logic              cfg_err_o
);
   if (!REG_GATE) begin : g_chk
      AST_IDLE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !enable_i |=> (gate_o == '1 && !entry_chg_o)); // R1
      AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(enable_i) |=> (entry_chg_o || cfg_err_o)); // R3
      AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(enable_i) && $past(enable_i, 2) && !$past(wr_en_i) && !entry_chg_o)
         |-> $stable(gate_o)); // R6
      AST_CONFLICT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (entry_chg_o && peer_event_i && !$rose(enable_i)) |=> conflict_err_o); // R7
      AST_CONFLICT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (conflict_err_o && !$rose(enable_i)) |=> conflict_err_o); // R7
      AST_CFG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cfg_err_o |-> (gate_o == '1 && !entry_chg_o)); // R8
   end
endmodule

bind gate_sched gate_sched_chk #(.NUM_TC(NUM_TC), .REG_GATE(REG_GATE)) u_gate_sched_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .enable_i(enable_i),
   .peer_event_i(peer_event_i), .gate_o(gate_o), .entry_chg_o(entry_chg_o),
   .conflict_err_o(conflict_err_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_gate_sched.sv
module test_gate_sched;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_NS    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [7:0]  wr_mask = '0;
   logic [23:0] wr_ivl = '0;
   logic [4:0]  num = 5'd1;
   logic        enable = 1'b0, tick = 1'b0, peer = 1'b0;
   logic [7:0]  gate;
   logic        chg, conflict, cfg_err;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_sched #(.TICK_NS(TICK_NS)) i_gate_sched (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
      .wr_mask_i(wr_mask), .wr_ivl_i(wr_ivl), .num_entries_i(num),
      .enable_i(enable), .tick_i(tick), .peer_event_i(peer),
      .gate_o(gate), .entry_chg_o(chg), .conflict_err_o(conflict),
      .cfg_err_o(cfg_err)
   );

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(string req, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic put(int idx, int m, int iv);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_mask = 8'(m); wr_ivl = 24'(iv);
      step();
      wr_en = 1'b0;
   endtask

   task automatic stop();
      tick = 1'b0; enable = 1'b0; peer = 1'b0;
      step();
   endtask

   task automatic t_reset();
      chk("R1 reset gate", gate, 8'hFF);
      chk("R1 reset chg", chg, 0);
      chk("R7 reset conflict", conflict, 0);
      chk("R8 reset cfg", cfg_err, 0);
   endtask

   task automatic t_example();
      put(0, 8'h80, 100); put(1, 8'h7F, 400); num = 2;
      enable = 1'b1; step();
      chk("R3 start gate", gate, 8'h80);
      chk("R6 start pulse", chg, 1);
      tick = 1'b1;
      for (int k = 1; k <= 9; k++) begin
         step();
         chk("R4 hold entry0", gate, 8'h80);
         chk("R6 no pulse", chg, 0);
      end
      step();
      chk("R2 entry1 mask", gate, 8'h7F);
      chk("R6 advance pulse", chg, 1);
      for (int k = 1; k <= 39; k++) step();
      chk("R4 entry1 last tick", gate, 8'h7F);
      step();
      chk("R5 wrap to entry0", gate, 8'h80);
      chk("R6 wrap pulse", chg, 1);
      tick = 1'b0; enable = 1'b0; step();
      chk("R1 disabled open", gate, 8'hFF);
      chk("R1 disabled no pulse", chg, 0);
   endtask

   task automatic t_sparse();
      put(0, 8'h01, 25); put(1, 8'h02, 10); num = 2;
      enable = 1'b1; step();
      chk("R2 class0 only", gate, 8'h01);
      tick = 1'b1; step(); tick = 1'b0; step();
      tick = 1'b1; step(); tick = 1'b0; step();
      chk("R4 two ticks hold", gate, 8'h01);
      tick = 1'b1; step();
      chk("R4 third tick advances", gate, 8'h02);
      chk("R6 pulse on advance", chg, 1);
      tick = 1'b0; step();
      chk("R6 single pulse", chg, 0);
      chk("R4 no tick no advance", gate, 8'h02);
      stop();
   endtask

   task automatic t_conflict();
      put(0, 8'h0F, 20); put(1, 8'hF0, 20); num = 2;
      enable = 1'b1; step();
      tick = 1'b1; step();
      tick = 1'b0; peer = 1'b1; step();
      chk("R7 peer without pulse ignored", conflict, 0);
      peer = 1'b0; tick = 1'b1; step();
      chk("R6 pulse present", chg, 1);
      tick = 1'b0; peer = 1'b1; step();
      peer = 1'b0;
      chk("R7 conflict set", conflict, 1);
      step(); step();
      chk("R7 conflict sticky", conflict, 1);
      enable = 1'b0; step();
      chk("R7 sticky while disabled", conflict, 1);
      enable = 1'b1; step();
      chk("R7 cleared on restart", conflict, 0);
      stop();
   endtask

   task automatic t_cfg();
      put(0, 8'h11, 30); put(1, 8'h22, 0); put(2, 8'h33, 30); num = 3;
      enable = 1'b1; step();
      chk("R8 zero interval flagged", cfg_err, 1);
      chk("R8 gates open", gate, 8'hFF);
      chk("R8 no pulse", chg, 0);
      tick = 1'b1;
      for (int k = 0; k < 5; k++) step();
      chk("R8 still not running", gate, 8'hFF);
      stop();
      chk("R8 flag sticky after disable", cfg_err, 1);
      num = 1; enable = 1'b1; step();
      chk("R8 unused zero entry ignored", cfg_err, 0);
      chk("R2 single entry mask", gate, 8'h11);
      tick = 1'b1; step(); step(); step();
      chk("R5 single entry repeat pulse", chg, 1);
      chk("R5 single entry mask kept", gate, 8'h11);
      stop();
      num = 0; enable = 1'b1; step();
      chk("R8 count zero", cfg_err, 1);
      stop();
      num = 17; enable = 1'b1; step();
      chk("R8 count seventeen", cfg_err, 1);
      chk("R8 count seventeen open", gate, 8'hFF);
      stop();
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) put(i, (i * 17) & 8'hFF, 10);
      num = 16; enable = 1'b1; step();
      chk("R3 full start", gate, 0);
      tick = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         step();
         chk("R5 sixteen entry walk", gate, ((k % 16) * 17) & 8'hFF);
      end
      stop();
   endtask

   task automatic t_restart();
      put(0, 8'h05, 50); put(1, 8'h0A, 50); num = 2;
      enable = 1'b1; step();
      tick = 1'b1; step(); step(); step();
      tick = 1'b0; enable = 1'b0; step();
      chk("R1 stopped mid entry", gate, 8'hFF);
      enable = 1'b1; step();
      chk("R3 restart at entry0", gate, 8'h05);
      chk("R3 restart pulse", chg, 1);
      tick = 1'b1;
      for (int k = 0; k < 4; k++) step();
      chk("R3 elapsed cleared", gate, 8'h05);
      step();
      chk("R3 full interval then advance", gate, 8'h0A);
      stop();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_example();
      t_sparse();
      t_conflict();
      t_cfg();
      t_full();
      t_restart();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule